// File: doc/BRIEF.md
# Rate One-Third Convolutional Encoder

This block applies a rate 1/3, constraint-length 9 convolutional code to a serial stream of information bits. Every accepted input bit yields three code symbols, one from each of three fixed parity generators (octal 557, 663 and 711). The symbols leave one per clock on a serial output with a valid strobe and a selector naming the generator. A new bit can be accepted every third cycle, so the symbol stream runs at three times the bit rate.

Frames carry 96 input bits. The zero tail that flushes the code is already in the input stream. A frame-start strobe clears the eight-bit history so that each frame is encoded on its own. The encoder counts the bits accepted since the last frame start and marks the final symbol of each 96th bit.

Top module: `tri_rate_conv_enc`

## Requirements
- R1: After reset, symValid and frameEnd are low and bitReady is high. The history is all zero, so the first bit encoded without a frame start uses a zero history.
- R2: An accepted bit (bitValid and bitReady high at a rising edge) makes symValid high for exactly the next three cycles. In those cycles symSel is 0, then 1, then 2, and the generator-0 symbol comes first.
- R3: Each symbol is the modulo-2 sum of the current bit and the eight previous bits, each weighted by a generator word. Bit 8 (the MSB) of the word weights the current bit, bit 7 weights the most recent previous bit, and so on down to bit 0, which weights the oldest. With symSel 0 the word is 101101111 (octal 557).
- R4: With symSel 1 the generator word is 110110011 (octal 663). With symSel 2 it is 111001001 (octal 711).
- R5: When frameStart is high at an edge, the history is cleared. A bit accepted in the same cycle is encoded as if all eight previous bits were zero.
- R6: bitReady is low while the symbols for symSel 0 and 1 are shown. It is high while symSel 2 is shown and when idle, so a held bitValid gives one bit every three cycles with symValid staying high.
- R7: While no bit is accepted, symValid stays low once the pending symbols are out, and the history holds its value.
- R8: frameEnd is high only together with the symSel 2 symbol of the 96th bit accepted since the last frame start (or since reset). After a frame whose last 8 bits are zero, the history is all zero.
- R9: A bitValid pulse while bitReady is low is ignored. It adds no symbols and does not change the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Clears history and the frame bit count |
| bitValid | input | 1 | Input bit offered |
| bitIn | input | 1 | Information bit |
| bitReady | output | 1 | Encoder can take a bit this cycle |
| symValid | output | 1 | symOut carries a code symbol |
| symOut | output | 1 | Serial code symbol |
| symSel | output | 2 | Generator index of the current symbol (0, 1, 2) |
| frameEnd | output | 1 | Last symbol of the frame's final bit |

## Verification
The three symbols of a bit accepted at one rising edge are due in the three cycles after that edge, generator 0 first. bitReady rises in the same cycle that the generator-2 symbol appears, and frameEnd goes with that symbol for the 96th bit. The bench keeps a queue of expected symbols. Each bit it hands over in a cycle where its own model says the encoder is ready pushes three entries. At every falling edge the bench pops one entry and compares symOut, symSel and frameEnd against it. An empty queue means symValid must be low. The bench also checks bitReady against whether the queue has just drained, so an accepted or refused bit shows up at the correct cycle.

// File: rtl/tce_pkg.sv
package tce_pkg;

  localparam int CONSTR_LEN = 9;
  localparam int HIST_BITS  = CONSTR_LEN - 1;
  localparam int NUM_GEN    = 3;
  localparam int SLOT_W     = $clog2(NUM_GEN + 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_GEN - 1);

  // Generator words: bit CONSTR_LEN-1 weights the current input,
  // lower bits weight older history bits.
  localparam logic [NUM_GEN-1:0][CONSTR_LEN-1:0] GEN_WORD = {
    9'o711,
    9'o663,
    9'o557
  };

  typedef struct packed {
    logic              load;      // bit accepted this cycle
    logic              clearHist; // frame start seen this cycle
    logic              emit;      // a symbol is being shown
    logic [SLOT_W-1:0] slot;      // which generator is shown
  } tceStrobe_t;

endpackage

// File: rtl/tce_ctrl.sv
module tce_ctrl
  import tce_pkg::*;
#(
  parameter int FRAME_BITS = 96
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStart,
  input  logic       bitValid,
  output logic       bitReady,
  output tceStrobe_t strobe,
  output logic       frameEnd
);

  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic              busy;
  logic [SLOT_W-1:0] slot;
  logic [CNT_W-1:0]  bitCnt;
  logic [CNT_W-1:0]  nextCnt;
  logic              lastBit;
  logic              accept;

  assign bitReady = !busy || (slot == LAST_SLOT);
  assign accept   = bitValid && bitReady;

  // slot sequencing: 0 .. NUM_GEN-1 after each accepted bit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      slot <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      slot <= '0;
    end else if (busy) begin
      if (slot == LAST_SLOT) begin
        busy <= 1'b0;
        slot <= '0;
      end else begin
        slot <= slot + SLOT_W'(1);
      end
    end
  end

  always_comb begin
    nextCnt = (frameStart ? '0 : bitCnt) + CNT_W'(1);
  end

  // position of the accepted bit inside its frame
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt  <= '0;
      lastBit <= 1'b0;
    end else if (accept) begin
      if (nextCnt == CNT_W'(FRAME_BITS)) begin
        bitCnt  <= '0;
        lastBit <= 1'b1;
      end else begin
        bitCnt  <= nextCnt;
        lastBit <= 1'b0;
      end
    end else if (frameStart) begin
      bitCnt <= '0;
    end
  end

  assign strobe.load      = accept;
  assign strobe.clearHist = frameStart;
  assign strobe.emit      = busy;
  assign strobe.slot      = slot;

  assign frameEnd = busy && (slot == LAST_SLOT) && lastBit;

endmodule

// File: rtl/tce_datapath.sv
module tce_datapath
  import tce_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  tceStrobe_t        strobe,
  input  logic              bitIn,
  output logic              symValid,
  output logic              symOut,
  output logic [SLOT_W-1:0] symSel
);

  logic [HIST_BITS-1:0]  histReg;
  logic [HIST_BITS-1:0]  histEff;
  logic [CONSTR_LEN-1:0] window;
  logic [NUM_GEN-1:0]    parity;
  logic [NUM_GEN-1:0]    symReg;

  // history as seen by the bit in this cycle (frame start zeroes it)
  assign histEff = strobe.clearHist ? '0 : histReg;
  assign window  = {bitIn, histEff};

  // one parity tree per generator
  for (genvar g = 0; g < NUM_GEN; g++) begin : gParity
    assign parity[g] = ^(window & GEN_WORD[g]);
  end

  // newest history bit sits at the MSB
  always_ff @(posedge clk) begin
    if (!rstN) begin
      histReg <= '0;
    end else if (strobe.load) begin
      histReg <= {bitIn, histEff[HIST_BITS-1:1]};
    end else if (strobe.clearHist) begin
      histReg <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      symReg <= '0;
    end else if (strobe.load) begin
      symReg <= parity;
    end
  end

  assign symValid = strobe.emit;
  assign symSel   = strobe.slot;
  assign symOut   = strobe.emit && symReg[strobe.slot];

endmodule

// File: rtl/tri_rate_conv_enc.sv
module tri_rate_conv_enc
  import tce_pkg::*;
#(
  parameter int FRAME_BITS = 96
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStart,
  input  logic       bitValid,
  input  logic       bitIn,
  output logic       bitReady,
  output logic       symValid,
  output logic       symOut,
  output logic [1:0] symSel,
  output logic       frameEnd
);

  tceStrobe_t strobe;

  tce_ctrl #(
    .FRAME_BITS(FRAME_BITS)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameStart(frameStart),
    .bitValid  (bitValid),
    .bitReady  (bitReady),
    .strobe    (strobe),
    .frameEnd  (frameEnd)
  );

  tce_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .bitIn   (bitIn),
    .symValid(symValid),
    .symOut  (symOut),
    .symSel  (symSel)
  );

endmodule

// File: rtl/tce_checker.sv
module tce_checker (
  input logic       clk,
  input logic       rstN,
  input logic       bitValid,
  input logic       bitReady,
  input logic       symValid,
  input logic [1:0] symSel,
  input logic       frameEnd
);

  // R2
  sym_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && bitReady) |=> (symValid && symSel == 2'd0));

  // R2
  sym_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (symValid && symSel != 2'd2) |=> (symValid && symSel == $past(symSel) + 2'd1));

  // R2
  sel_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    symValid |-> (symSel != 2'd3));

  // R6
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (symValid && symSel != 2'd2) |-> !bitReady);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(bitValid && bitReady) && (!symValid || symSel == 2'd2)) |=> !symValid);

  // R8
  frame_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |-> (symValid && symSel == 2'd2));

endmodule

bind tri_rate_conv_enc tce_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .bitValid(bitValid),
  .bitReady(bitReady),
  .symValid(symValid),
  .symSel  (symSel),
  .frameEnd(frameEnd)
);

// File: tb/tri_rate_conv_enc_bench.sv
`timescale 1ns/1ps
module tri_rate_conv_enc_bench;

  localparam int FRAME = 96;

  logic       clk = 1'b0;
  logic       rstN;
  logic       frameStart;
  logic       bitValid;
  logic       bitIn;
  logic       bitReady;
  logic       symValid;
  logic       symOut;
  logic [1:0] symSel;
  logic       frameEnd;

  always #2.5 clk = ~clk;

  tri_rate_conv_enc u_tri_rate_conv_enc (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .bitValid(bitValid),
    .bitIn(bitIn), .bitReady(bitReady), .symValid(symValid), .symOut(symOut),
    .symSel(symSel), .frameEnd(frameEnd)
  );

  typedef struct {
    bit sym;
    int sel;
    bit last;
  } expSym_t;

  expSym_t   expQ[$];
  bit [8:0]  genTab[3] = '{9'b101101111, 9'b110110011, 9'b111001001};
  bit [7:0]  mHist;      // [0] most recent
  int        mCnt;
  int        tests = 0;
  int        fails = 0;
  bit        done  = 0;

  function automatic bit codeBit(int g, bit b, bit [7:0] h);
    bit p;
    p = b & genTab[g][8];
    for (int k = 1; k <= 8; k++) p ^= h[k-1] & genTab[g][8-k];
    return p;
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // sample outputs, then drive new inputs and advance the model
  task automatic cycle(input bit fs, input bit v, input bit b, output bit took);
    expSym_t e;
    bit rdy;
    bit [7:0] h;
    @(negedge clk);
    if (expQ.size() > 0) begin
      e = expQ.pop_front();
      check("R2 symValid", symValid, 1);
      check("R2 symSel order", symSel, e.sel);
      if (e.sel == 0) check("R3 g0 symbol", symOut, e.sym);
      else            check("R4 g1/g2 symbol", symOut, e.sym);
      check("R8 frameEnd", frameEnd, e.last);
    end else begin
      check("R7 idle symValid", symValid, 0);
      check("R8 idle frameEnd", frameEnd, 0);
    end
    rdy = (expQ.size() == 0);
    check("R6 bitReady", bitReady, rdy);
    frameStart = fs;
    bitValid   = v;
    bitIn      = b;
    took = v && rdy;   // R9: not-ready offers are dropped by the model
    if (took) begin
      h = fs ? 8'h00 : mHist;           // R5
      mCnt = (fs ? 0 : mCnt) + 1;
      for (int g = 0; g < 3; g++) begin
        e.sym  = codeBit(g, b, h);
        e.sel  = g;
        e.last = (g == 2) && (mCnt == FRAME);
        expQ.push_back(e);
      end
      if (mCnt == FRAME) mCnt = 0;
      mHist = {h[6:0], b};
    end else if (fs) begin
      mHist = 8'h00;
      mCnt  = 0;
    end
  endtask

  task automatic sendBit(input bit fs, input bit b);
    bit took;
    do cycle(fs, 1'b1, b, took); while (!took);
  endtask

  task automatic idle(input int n);
    bit took;
    for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, 1'b0, took);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit took;
    void'($urandom(32'h5eed_1234));
    rstN = 1'b0; frameStart = 1'b0; bitValid = 1'b0; bitIn = 1'b0;
    mHist = '0; mCnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 symValid in reset", symValid, 0);
    check("R1 bitReady in reset", bitReady, 1);
    check("R1 frameEnd in reset", frameEnd, 0);
    rstN = 1'b1;
    // R1 first bits after reset without frame start: zero history
    sendBit(1'b0, 1'b1);
    sendBit(1'b0, 1'b1);
    idle(5);
    // R3/R4 impulse response after frame start
    sendBit(1'b1, 1'b1);
    for (int i = 0; i < 8; i++) sendBit(1'b0, 1'b0);
    idle(4);
    // R5 frame start with a bit after dirty history
    sendBit(1'b0, 1'b1);
    sendBit(1'b0, 1'b1);
    sendBit(1'b1, 1'b1);
    // R5 standalone frame start clears history
    idle(4);
    cycle(1'b1, 1'b0, 1'b0, took);
    sendBit(1'b0, 1'b1);
    idle(4);
    // R8 full frame with zero tail, then a bit with no frame start
    for (int i = 0; i < FRAME; i++)
      sendBit(i == 0, (i < FRAME - 8) ? 1'($urandom_range(0, 1)) : 1'b0);
    sendBit(1'b0, 1'b1);
    // R6 back-to-back held valid
    for (int i = 0; i < 30; i++) sendBit(1'b0, 1'($urandom_range(0, 1)));
    idle(4);
    // R9 offers while busy and R7 idle gaps, random mix
    for (int i = 0; i < 6000; i++)
      cycle(($urandom_range(0, 59) == 0), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), took);
    // R8 frame count over several whole frames
    for (int i = 0; i < 3 * FRAME; i++)
      sendBit(i == 0, 1'($urandom_range(0, 1)));
    idle(6);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule